// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial management slave that holds the configuration bytes of a clock generator. It runs on a fast system clock and oversamples the two bus lines. It finds start and stop conditions and shifts bytes in and out on the clock edges it detects. It only ever pulls the data line low, because the line is open-drain.

A write carries the device address, then a command byte and a length byte, then data. The slave acknowledges the command and length bytes and throws their values away. Data bytes then fill register 0, register 1 and so on upward. A read returns the length 7, then registers 0 to 6 in order. The register values drive the neighbouring clock-gating logic through a flat output bus. Some bits report strap pins. The PCI stop request combines a pin and a register bit.

The controller has seven states. IDLE waits for a start. ADDR shifts in the address byte. It moves to ADDR_ACK on a matching address and back to IDLE on any other address. ADDR_ACK goes to RX for a write or TX for a read. RX and RX_ACK alternate for each received byte. TX and TX_ACK alternate for each sent byte. TX_ACK returns to IDLE on a host NACK. From every state, a stop condition leads to IDLE and a start condition leads to ADDR.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The 8-bit address D2h (write) and D3h (read) are acknowledged: `sda_oe` is high during the ninth clock of the address byte.
- R2: Any other address gets no acknowledge. The slave stays quiet until the next start condition, and no register changes.
- R3: On a write, the first two bytes after the address are a command byte and a length byte. Both are acknowledged and their values have no effect.
- R4: Data bytes are written to register 0, then 1, 2, and so on upward. A stop after any complete byte ends the transfer and keeps every byte already written.
- R5: Every received byte is acknowledged. This includes bytes past register 6, which are discarded.
- R6: A read returns 07h first, then registers 0 to 6, MSB first. A host NACK ends the read and the slave releases SDA.
- R7: After reset the registers hold these values: register 0 has bits 7 and 5 at 0; register 1 is 47h ORed with the live multiplier strap in bit 7; register 2 is 7Fh; register 3 is C7h; register 4 is 3Fh; register 5 is 00h. The writable bits are: register 0 bits 7 and 5; register 1 bits 6, 2, 1 and 0; register 2 bits 6:0; register 3 all bits; register 4 bits 5:0; register 5 bits 3:0. Reserved bits read 0.
- R8: Register 0 bit 1 holds `strap_fsel[0]` and bit 2 holds `strap_fsel[1]`, both captured while reset is asserted and held after reset is released. Register 1 bit 7 always shows the current level of `strap_msel`.
- R9: When `stop_sw_mode` is 0, register 0 bit 3 reads the level of `stop_pin_n` and writes to it are ignored. When `stop_sw_mode` is 1, bit 3 is a stored bit that resets to 1. `pci_stop_req` is high when `stop_pin_n` is low, or when software mode is on and bit 3 is 0.
- R10: Register 6 is read-only and equals {REV_ID, 4'b0001}. Writes to read-only or reserved bits have no effect.
- R11: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A stop returns the slave to idle with SDA released.
- R12: `cfg_bytes[8*i+7:8*i]` shows the live read value of register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset; the straps are captured while it is low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_fsel | input | 2 | Frequency-select straps |
| strap_msel | input | 1 | Multiplier-select strap, read live |
| stop_pin_n | input | 1 | Active-low PCI stop pin |
| stop_sw_mode | input | 1 | 1 selects software control of the stop bit |
| cfg_bytes | output | 56 | Read values of registers 0 to 6 |
| pci_stop_req | output | 1 | Combined PCI stop request |

## Verification
The hardest cases to reach are the ones that need a host to misbehave on purpose. Examples are a read cut short by a NACK straight after the length byte, a write that runs one byte past the last register, and a strap that changes after reset has been released. The bench host model has a separate task for each of these. Each task then runs a complete read to confirm that the register file and the bus state are what the requirements predict. The stop bit is exercised in both modes, with the pin toggled between writes.

// File: rtl/cfg_smbus_pkg.sv
package cfg_smbus_pkg;

    localparam int NUM_REGS = 7;
    localparam int IDX_W    = 3;
    localparam logic [7:0] READ_LEN = 8'd7;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK
    } state_t;

    typedef enum logic [1:0] {
        PH_CMD, PH_LEN, PH_DATA
    } wphase_t;

    // writable bits per stored register (register 6 is constant)
    function automatic logic [7:0] rw_mask(input int idx);
        case (idx)
            0:       return 8'hA0;
            1:       return 8'h47;
            2:       return 8'h7F;
            3:       return 8'hFF;
            4:       return 8'h3F;
            5:       return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            1:       return 8'h47;
            2:       return 8'h7F;
            3:       return 8'hC7;
            4:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int W = SYNC_STAGES + 1;

    logic [W-1:0] scl_v, sda_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_v <= '1;
            sda_v <= '1;
        end else begin
            scl_v <= {scl_v[W-2:0], scl_i};
            sda_v <= {sda_v[W-2:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_old;
    assign scl_now   = scl_v[W-2];
    assign scl_old   = scl_v[W-1];
    assign sda_s     = sda_v[W-2];
    assign sda_old   = sda_v[W-1];
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_det = scl_now & scl_old & sda_old & ~sda_s;
    assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_smbus_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [1:0]            strap_fsel,
    input  logic                  strap_msel,
    input  logic                  stop_pin_n,
    input  logic                  stop_sw_mode,
    output logic [8*NUM_REGS-1:0] rd_bytes,
    output logic                  pci_stop_req
);
    localparam int NSTORE = NUM_REGS - 1;
    localparam int ID_LSB = 8 * NSTORE;

    logic [1:0] fsel_q;
    logic       stop_bit_q;
    logic [7:0] stored [NSTORE];

    // straps follow the pins only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) fsel_q <= strap_fsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stop_bit_q <= 1'b1;
        else if (wr_en && wr_idx == '0 && stop_sw_mode)
            stop_bit_q <= wr_data[3];
    end

    for (genvar g = 0; g < NSTORE; g++) begin : g_reg
        localparam logic [7:0] MASK = rw_mask(g);
        localparam logic [7:0] DEF  = reset_value(g);
        logic [7:0] q_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_r <= DEF;
            else if (wr_en && wr_idx == IDX_W'(g))
                q_r <= wr_data & MASK;
        end
        assign stored[g] = q_r;
    end

    always_comb begin
        rd_bytes = '0;
        for (int i = 0; i < NSTORE; i++) rd_bytes[8*i +: 8] = stored[i];
        rd_bytes[1]  = fsel_q[0];
        rd_bytes[2]  = fsel_q[1];
        rd_bytes[3]  = stop_sw_mode ? stop_bit_q : stop_pin_n;
        rd_bytes[15] = strap_msel;
        rd_bytes[ID_LSB +: 8] = {REV_ID, 4'b0001};
    end

    assign pci_stop_req = ~stop_pin_n | (stop_sw_mode & ~stop_bit_q);
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
    import cfg_smbus_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter logic [3:0] REV_ID      = 4'h2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  strap_fsel,
    input  logic        strap_msel,
    input  logic        stop_pin_n,
    input  logic        stop_sw_mode,
    output logic [55:0] cfg_bytes,
    output logic        pci_stop_req
);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    smbus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    state_t           state_q, state_d;
    wphase_t          phase_q;
    logic [3:0]       cnt_q;
    logic [7:0]       shreg_q, txsh_q;
    logic [IDX_W-1:0] idx_q;
    logic             rw_q, hack_q;
    logic             byte_done, wr_en;

    assign byte_done = scl_fall && cnt_q == 4'd8;
    assign wr_en = state_q == S_RX && byte_done && !start_det && !stop_det
                   && phase_q == PH_DATA && idx_q != IDX_END;

    cfg_regfile #(.REV_ID(REV_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx_q),
        .wr_data(shreg_q), .strap_fsel(strap_fsel), .strap_msel(strap_msel),
        .stop_pin_n(stop_pin_n), .stop_sw_mode(stop_sw_mode),
        .rd_bytes(cfg_bytes), .pci_stop_req(pci_stop_req)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (stop_det)       state_d = S_IDLE;
        else if (start_det) state_d = S_ADDR;
        else begin
            unique case (state_q)
                S_IDLE: state_d = S_IDLE;
                S_ADDR: if (byte_done)
                            state_d = (shreg_q[7:1] == SLAVE_ADDR) ? S_AACK : S_IDLE;
                S_AACK: if (scl_fall) state_d = rw_q ? S_TX : S_RX;
                S_RX:   if (byte_done) state_d = S_RACK;
                S_RACK: if (scl_fall) state_d = S_RX;
                S_TX:   if (byte_done) state_d = S_TACK;
                S_TACK: if (scl_fall) state_d = hack_q ? S_TX : S_IDLE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            shreg_q <= '0;
            txsh_q  <= '1;
            idx_q   <= '0;
            rw_q    <= 1'b0;
            hack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_det || stop_det) begin
                cnt_q <= '0;
            end else begin
                unique case (state_q)
                    S_ADDR, S_RX: begin
                        if (scl_rise) begin
                            shreg_q <= {shreg_q[6:0], sda_s};
                            cnt_q   <= cnt_q + 4'd1;
                        end else if (byte_done) begin
                            cnt_q <= '0;
                            if (state_q == S_ADDR) rw_q <= shreg_q[0];
                            else if (phase_q == PH_CMD) phase_q <= PH_LEN;
                            else if (phase_q == PH_LEN) phase_q <= PH_DATA;
                            else if (idx_q != IDX_END) idx_q <= idx_q + 1'b1;
                        end
                    end
                    S_AACK: if (scl_fall) begin
                        cnt_q   <= '0;
                        phase_q <= PH_CMD;
                        idx_q   <= '0;
                        txsh_q  <= READ_LEN;
                    end
                    S_TX: begin
                        if (scl_rise) cnt_q <= cnt_q + 4'd1;
                        else if (byte_done) cnt_q <= '0;
                        else if (scl_fall && cnt_q != 4'd0) txsh_q <= {txsh_q[6:0], 1'b1};
                    end
                    S_TACK: begin
                        if (scl_rise) hack_q <= ~sda_s;
                        else if (scl_fall) begin
                            txsh_q <= (idx_q != IDX_END) ? cfg_bytes[8*idx_q +: 8] : 8'hFF;
                            if (idx_q != IDX_END) idx_q <= idx_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // open-drain output decode
    always_comb begin
        unique case (state_q)
            S_AACK, S_RACK: sda_oe = 1'b1;
            S_TX:           sda_oe = ~txsh_q[7];
            default:        sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_smbus_checker.sv
module cfg_smbus_checker
    import cfg_smbus_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input state_t      state_q,
    input logic [3:0]  cnt_q,
    input logic        scl_fall,
    input logic        start_det,
    input logic        stop_det,
    input logic        sda_oe,
    input logic [55:0] cfg_bytes,
    input logic        stop_pin_n,
    input logic        pci_stop_req
);
    a_r11_stop_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == S_IDLE && !sda_oe));

    a_r2_drive_only_when_owed: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state_q == S_AACK || state_q == S_RACK || state_q == S_TX));

    a_r5_ack_after_rx_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RX && scl_fall && cnt_q == 4'd8 && !start_det && !stop_det) |=> sda_oe);

    a_r8_fsel_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_bytes[2:1]));

    a_r10_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_bytes[55:48]));

    a_r9_pin_forces_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_pin_n |-> pci_stop_req);
endmodule

bind cfg_smbus_slave cfg_smbus_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .cnt_q(cnt_q),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .cfg_bytes(cfg_bytes), .stop_pin_n(stop_pin_n),
    .pci_stop_req(pci_stop_req)
);

// File: tb/cfg_smbus_slave_test.sv
module cfg_smbus_slave_test;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, host_sda = 1'b1;
    logic [1:0] fsel = 2'b10;
    logic msel = 1'b1, pin_n = 1'b1, swm = 1'b0;
    logic sda_oe, stop_req;
    logic [55:0] bytes;
    wire  sda_bus = host_sda & ~sda_oe;
    int vectors = 0, errors = 0;

    always #2.5 clk = ~clk;

    cfg_smbus_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_fsel(fsel), .strap_msel(msel), .stop_pin_n(pin_n),
        .stop_sw_mode(swm), .cfg_bytes(bytes), .pci_stop_req(stop_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; scl = 1'b1; wq(Q);
        host_sda = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        host_sda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wq(Q);
            scl = 1'b1; wq(2*Q);
            scl = 1'b0; wq(Q);
        end
        host_sda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        acked = ~sda_bus; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            host_sda = 1'b1; wq(Q);
            scl = 1'b1; wq(Q);
            b[i] = sda_bus; wq(Q);
            scl = 1'b0; wq(Q);
        end
        host_sda = ~give_ack; wq(Q);
        scl = 1'b1; wq(2*Q);
        scl = 1'b0; wq(Q);
        host_sda = 1'b1;
    endtask

    // write: address, command, length, then data bytes; every ack checked
    task automatic do_write(input logic [7:0] cmd, input logic [7:0] len,
                            input logic [7:0] d [], input string req);
        logic a;
        bus_start();
        send_byte(8'hD2, a);  chk("R1 write address ack", {7'd0, a}, 8'd1);
        send_byte(cmd, a);    chk({req, " R3 command ack"}, {7'd0, a}, 8'd1);
        send_byte(len, a);    chk({req, " R3 length ack"}, {7'd0, a}, 8'd1);
        foreach (d[i]) begin
            send_byte(d[i], a); chk({req, " R5 data ack"}, {7'd0, a}, 8'd1);
        end
        bus_stop();
    endtask

    task automatic read_expect(input logic [7:0] e [8], input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a); chk("R1 read address ack", {7'd0, a}, 8'd1);
        for (int i = 0; i < 8; i++) begin
            recv_byte(i < 7, b);
            chk($sformatf("%s R6 read byte %0d", req, i), b, e[i]);
        end
        bus_stop();
        chk("R11 released after stop", {7'd0, sda_oe}, 8'd0);
    endtask

    task automatic t_reset();
        chk("R7 reg2 at port", bytes[23:16], 8'h7F);
        chk("R12 reg4 at port", bytes[39:32], 8'h3F);
        chk("R9 no stop after reset", {7'd0, stop_req}, 8'd0);
        read_expect('{8'h07, 8'h0C, 8'hC7, 8'h7F, 8'hC7, 8'h3F, 8'h00, 8'h21}, "R7 reset");
    endtask

    task automatic t_full_write();
        do_write(8'h00, 8'h07, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R4 full");
        read_expect('{8'h07, 8'hAC, 8'hC7, 8'h7F, 8'hFF, 8'h3F, 8'h0F, 8'h21}, "R10 masks");
    endtask

    task automatic t_partial_write();
        do_write(8'h00, 8'h07, '{8'h00, 8'h00}, "R4 partial");
        read_expect('{8'h07, 8'h0C, 8'h80, 8'h7F, 8'hFF, 8'h3F, 8'h0F, 8'h21}, "R4 partial");
    endtask

    task automatic t_bad_address();
        logic a;
        bus_start();
        send_byte(8'hA0, a); chk("R2 no ack for A0h", {7'd0, a}, 8'd0);
        send_byte(8'h00, a); chk("R2 quiet after bad address", {7'd0, a}, 8'd0);
        bus_stop();
        chk("R2 reg0 untouched", bytes[7:0], 8'h0C);
    endtask

    task automatic t_cmd_ignored();
        do_write(8'h05, 8'h01, '{8'h20}, "R3 ignored");
        chk("R3 data lands in reg0", bytes[7:0], 8'h2C);
        chk("R3 reg1 untouched", bytes[15:8], 8'h80);
    endtask

    task automatic t_straps();
        fsel = 2'b01; msel = 1'b0; wq(4);
        chk("R8 fsel held after reset", bytes[7:0], 8'h2C);
        chk("R8 msel live", bytes[15:8], 8'h00);
    endtask

    task automatic t_stop_modes();
        pin_n = 1'b0; wq(4);
        chk("R9 hw pin low request", {7'd0, stop_req}, 8'd1);
        chk("R9 hw bit3 shows pin", bytes[7:0], 8'h24);
        do_write(8'h00, 8'h01, '{8'h08}, "R9 hw");
        chk("R9 hw write ignored", bytes[7:0], 8'h04);
        pin_n = 1'b1; wq(4);
        chk("R9 hw pin high", bytes[7:0], 8'h0C);
        chk("R9 hw no request", {7'd0, stop_req}, 8'd0);
        swm = 1'b1; wq(4);
        chk("R9 sw default one", bytes[7:0], 8'h0C);
        do_write(8'h00, 8'h01, '{8'h00}, "R9 sw");
        chk("R9 sw bit cleared", bytes[7:0], 8'h04);
        chk("R9 sw request", {7'd0, stop_req}, 8'd1);
        do_write(8'h00, 8'h01, '{8'h08}, "R9 sw");
        chk("R9 sw release", {7'd0, stop_req}, 8'd0);
        swm = 1'b0; wq(4);
    endtask

    task automatic t_early_nack();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a); chk("R1 read ack", {7'd0, a}, 8'd1);
        recv_byte(1'b0, b);  chk("R6 length byte", b, 8'h07);
        wq(Q);
        chk("R6 released after nack", {7'd0, sda_bus}, 8'd1);
        bus_stop();
        read_expect('{8'h07, 8'h0C, 8'h00, 8'h7F, 8'hFF, 8'h3F, 8'h0F, 8'h21}, "R6 after nack");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wq(10);
        rst_n = 1'b1;
        wq(10);
        t_reset();
        t_full_write();
        t_partial_write();
        t_bad_address();
        t_cmd_ignored();
        t_straps();
        t_stop_modes();
        t_early_nack();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule